// File: doc/BRIEF.md
# Holdover Announce Injection Controller

This block sequences the emergency transmission of clock-quality announcements when the local timing reference drops into holdover. On a rising edge of the holdover status it takes a snapshot of the per-port master mask. It then asks a separate frame injector to send one announcement on each selected port, one port at a time. Ports are served from the lowest set bit upward, and a programmable idle gap separates consecutive frames. While the sweep runs, the host network-interface path is stalled so that its frames cannot interleave with the injected ones.

Once a sweep has started it runs to completion, whatever happens on the holdover input or the mask. When every selected port has reported done, the controller rests in a latched holdover state and ignores the status input until holdover goes low again. Only then does it re-arm for the next rising edge. If the mask is empty at the moment of the trigger, the controller latches directly, without stalling the host path or issuing any strobe.

Top module: `holdover_announce_ctrl`

## Requirements
- R1: While reset is active and on the first cycles after it, `inj_start_o` and `host_stall_o` are low. The holdover input is treated as having been low before reset, so a high input at reset release counts as a rising edge.
- R2: A sweep starts only on a rising edge of `holdover_i` seen in the idle state. The first strobe is visible in the clock cycle right after the edge at which the high level is first sampled.
- R3: Ports are served in increasing bit order (bit 0 first) of the mask value sampled at the trigger edge. Changes to `master_mask_i` during the sweep have no effect. `inj_port_o` carries the binary index of the port being served.
- R4: Each selected port gets exactly one single-cycle `inj_start_o` pulse. The controller then waits for `inj_done_i`, and a done pulse outside that wait has no effect.
- R5: After the done of a port that is not the last one, the next strobe appears exactly max(G,1)+1 cycles after the cycle in which done was high. G is the value of `gap_len_i` sampled in that done cycle.
- R6: `host_stall_o` is high from the first strobe cycle through the done cycle of the last port. It is low in the cycle after that.
- R7: A sweep cannot be aborted. A falling edge of holdover during the sweep does not stop or shorten it.
- R8: After the sweep the controller stays latched. While holdover remains high it issues no strobe and no stall.
- R9: In the latched state a low `holdover_i` returns the controller to idle, and a later rising edge starts a new sweep. This also holds when holdover falls in the same cycle as the final done.
- R10: If the sampled mask is all zeros, the controller latches with no strobe and no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| holdover_i | input | 1 | Holdover status of the timing reference |
| master_mask_i | input | NPORTS | One bit per port; set bits receive an announcement |
| gap_len_i | input | GAP_W | Idle cycles between frames (0 behaves as 1) |
| inj_done_i | input | 1 | Pulse from the frame injector: current frame finished |
| inj_start_o | output | 1 | Single-cycle request to inject on `inj_port_o` |
| inj_port_o | output | log2(NPORTS) | Index of the port being served |
| host_stall_o | output | 1 | Holds off host NIC traffic during the sweep |

## Verification
The finishing of a port and the end of holdover can land in the same cycle: the last done pulse and a holdover falling edge. The bench provokes this by watching its scheduled injector reply and dropping holdover on exactly that negedge. It then judges the outcome by requiring stall to release on the next cycle and a following rising edge to start a full new sweep in the expected order. A second overlap, a holdover drop while a sweep is in flight, is checked by confirming that every queued port is still served with the correct spacing.

// File: rtl/hac_pkg.sv
`timescale 1ns/1ps
package hac_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ISSUE = 3'd1,
    ST_WAIT  = 3'd2,
    ST_GAP   = 3'd3,
    ST_HELD  = 3'd4
  } hac_state_e;
endpackage

// File: rtl/hac_rst_sync.sv
`timescale 1ns/1ps
module hac_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/hac_lsb_pick.sv
`timescale 1ns/1ps
module hac_lsb_pick #(
  parameter int N  = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic [N-1:0]  onehot
);
  always_comb begin
    onehot = vec & (~vec + 1'b1);
    idx    = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/hac_gap_timer.sv
`timescale 1ns/1ps
module hac_gap_timer #(
  parameter int GAP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [GAP_W-1:0] len,
  output logic             expired
);
  logic [GAP_W-1:0] cnt_q;
  logic             cnt_en;

  assign cnt_en = (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (load)   cnt_q <= len;
    else if (cnt_en) cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q <= GAP_W'(1));
endmodule

// File: rtl/holdover_announce_ctrl.sv
`timescale 1ns/1ps
module holdover_announce_ctrl #(
  parameter int  NPORTS = 8,
  parameter int  GAP_W  = 8,
  localparam int PORT_W = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              holdover_i,
  input  logic [NPORTS-1:0] master_mask_i,
  input  logic [GAP_W-1:0]  gap_len_i,
  input  logic              inj_done_i,
  output logic              inj_start_o,
  output logic [PORT_W-1:0] inj_port_o,
  output logic              host_stall_o
);
  import hac_pkg::*;

  logic              srst_n;
  hac_state_e        state_q, state_d;
  logic [NPORTS-1:0] work_q, work_d, pick_oh, remain;
  logic              work_en;
  logic              hold_q;
  logic              hold_rise;
  logic              gap_load, gap_expired;
  logic              in_wait, done_seen;

  hac_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .srst_n(srst_n)
  );

  hac_lsb_pick #(.N(NPORTS)) u_pick (
    .vec(work_q), .idx(inj_port_o), .onehot(pick_oh)
  );

  hac_gap_timer #(.GAP_W(GAP_W)) u_gap (
    .clk(clk), .rst_n(srst_n), .load(gap_load),
    .len(gap_len_i), .expired(gap_expired)
  );

  assign hold_rise = holdover_i & ~hold_q;
  assign in_wait   = (state_q == ST_WAIT);
  assign done_seen = in_wait & inj_done_i;
  assign remain    = work_q & ~pick_oh;

  // next-state logic
  always_comb begin
    state_d  = state_q;
    work_d   = work_q;
    work_en  = 1'b0;
    gap_load = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (hold_rise) begin
          work_en = 1'b1;
          work_d  = master_mask_i;
          state_d = (master_mask_i != '0) ? ST_ISSUE : ST_HELD;
        end
      end
      ST_ISSUE: state_d = ST_WAIT;
      ST_WAIT: begin
        if (done_seen) begin
          work_en = 1'b1;
          work_d  = remain;
          if (remain == '0) begin
            state_d = ST_HELD;
          end else begin
            state_d  = ST_GAP;
            gap_load = 1'b1;
          end
        end
      end
      ST_GAP:  if (gap_expired) state_d = ST_ISSUE;
      ST_HELD: if (!holdover_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q <= ST_IDLE;
      hold_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      hold_q  <= holdover_i;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)      work_q <= '0;
    else if (work_en) work_q <= work_d;
  end

  assign inj_start_o  = (state_q == ST_ISSUE);
  assign host_stall_o = (state_q == ST_ISSUE) || (state_q == ST_WAIT) ||
                        (state_q == ST_GAP);
endmodule

// File: rtl/hac_chk.sv
`timescale 1ns/1ps
module hac_chk (
  input logic clk,
  input logic rst_n,
  input logic holdover_i,
  input logic inj_done_i,
  input logic inj_start_o,
  input logic host_stall_o,
  input logic in_wait
);
  assert_strobe_in_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    inj_start_o |-> host_stall_o);

  assert_single_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    inj_start_o |=> !inj_start_o);

  assert_gap_after_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wait && inj_done_i) |=> !inj_start_o);

  assert_stall_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_stall_o) |-> $past(holdover_i));

  assert_stall_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(host_stall_o) |-> $past(inj_done_i));
endmodule

bind holdover_announce_ctrl hac_chk u_chk (
  .clk(clk), .rst_n(rst_n), .holdover_i(holdover_i), .inj_done_i(inj_done_i),
  .inj_start_o(inj_start_o), .host_stall_o(host_stall_o), .in_wait(in_wait)
);

// File: tb/tb_holdover_announce_ctrl.sv
`timescale 1ns/1ps
module tb_holdover_announce_ctrl;
  localparam int NP  = 8;
  localparam int GW  = 8;
  localparam int PW  = 3;
  localparam int LAT = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          holdover_i = 1'b0;
  logic [NP-1:0] master_mask_i = '0;
  logic [GW-1:0] gap_len_i = '0;
  logic          inj_done_i = 1'b0;
  logic          inj_start_o;
  logic [PW-1:0] inj_port_o;
  logic          host_stall_o;

  holdover_announce_ctrl #(.NPORTS(NP), .GAP_W(GW)) dut (
    .clk(clk), .rst_n(rst_n), .holdover_i(holdover_i),
    .master_mask_i(master_mask_i), .gap_len_i(gap_len_i),
    .inj_done_i(inj_done_i), .inj_start_o(inj_start_o),
    .inj_port_o(inj_port_o), .host_stall_o(host_stall_o)
  );

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  int exp_q[$];
  int cyc = 0, trig_cyc = 0, last_done = 0, done_at = 0, space = 0;
  int strobe_cnt = 0;
  bit arm_first = 0, first_pend = 0, have_done = 0, done_pend = 0;
  bit extra_done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor + injector model
  initial begin
    forever begin
      @(negedge clk); #1;
      cyc++;
      if (arm_first) begin
        trig_cyc = cyc; arm_first = 0; first_pend = 1; have_done = 0;
      end
      inj_done_i = 1'b0;
      if (extra_done) begin inj_done_i = 1'b1; extra_done = 0; end
      if (done_pend && cyc == done_at) begin
        chk(host_stall_o == 1'b1, "R6 stall at done", int'(host_stall_o), 1);
        inj_done_i = 1'b1; done_pend = 0; last_done = cyc; have_done = 1;
      end else if (have_done && !done_pend && exp_q.size() == 0 && cyc == last_done + 1) begin
        chk(host_stall_o == 1'b0, "R6/R9 stall after last done", int'(host_stall_o), 0);
      end
      if (inj_start_o) begin
        strobe_cnt++;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R4/R8 unexpected strobe", int'(inj_port_o), -1);
        end else begin
          int e;
          e = exp_q.pop_front();
          chk(int'(inj_port_o) == e, "R3 port order", int'(inj_port_o), e);
          chk(host_stall_o == 1'b1, "R6 stall at strobe", int'(host_stall_o), 1);
          if (first_pend) begin
            chk(cyc == trig_cyc + 1, "R2 first strobe latency", cyc - trig_cyc, 1);
            first_pend = 0;
          end else if (have_done) begin
            chk(cyc - last_done == space, "R5 gap spacing", cyc - last_done, space);
          end
          done_pend = 1; done_at = cyc + LAT;
        end
      end
    end
  end

  // driver: push expected ports and raise holdover
  task automatic start_sweep(input logic [NP-1:0] m, input int g);
    @(negedge clk);
    for (int i = 0; i < NP; i++) if (m[i]) exp_q.push_back(i);
    space = ((g < 1) ? 1 : g) + 1;
    master_mask_i = m;
    gap_len_i = GW'(g);
    holdover_i = 1'b1;
    arm_first = (m != '0);
  endtask

  task automatic wait_sweep();
    int guard = 0;
    do begin @(negedge clk); guard++; end
    while ((exp_q.size() != 0 || done_pend || arm_first || first_pend) && guard < 2000);
    chk(guard < 2000, "R7 sweep completes", guard, 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic drop_hold();
    @(negedge clk); holdover_i = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int s0;
    repeat (3) @(negedge clk);
    chk(inj_start_o == 1'b0, "R1 strobe in reset", int'(inj_start_o), 0);
    chk(host_stall_o == 1'b0, "R1 stall in reset", int'(host_stall_o), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(host_stall_o == 1'b0, "R1 stall after reset", int'(host_stall_o), 0);

    // R2/R3/R5/R6: main sweep, mask changed mid-sweep (ignored)
    start_sweep(8'b1010_0110, 3);
    repeat (4) @(negedge clk);
    master_mask_i = 8'hFF;
    wait_sweep();

    // R8: latched, no retrigger while high
    s0 = strobe_cnt;
    repeat (20) @(negedge clk);
    chk(strobe_cnt == s0, "R8 no strobe in held", strobe_cnt - s0, 0);
    chk(host_stall_o == 1'b0, "R8 no stall in held", int'(host_stall_o), 0);
    drop_hold();

    // R4: done while idle ignored
    extra_done = 1;
    s0 = strobe_cnt;
    repeat (6) @(negedge clk);
    chk(strobe_cnt == s0 && host_stall_o == 1'b0, "R4 stray done ignored", strobe_cnt - s0, 0);

    // R10: empty mask
    start_sweep(8'h00, 2);
    repeat (10) @(negedge clk);
    chk(strobe_cnt == s0, "R10 empty mask no strobe", strobe_cnt - s0, 0);
    chk(host_stall_o == 1'b0, "R10 empty mask no stall", int'(host_stall_o), 0);
    drop_hold();

    // R5 zero gap, ends served
    start_sweep(8'h81, 0);
    wait_sweep();
    drop_hold();

    // R7: holdover falls mid-sweep; sweep still completes
    start_sweep(8'b0101_1000, 5);
    repeat (3) @(negedge clk);
    holdover_i = 1'b0;
    wait_sweep();
    repeat (3) @(negedge clk);

    // R9: fall in same cycle as final done, then new rise
    start_sweep(8'b0001_0001, 1);
    do @(negedge clk); while (!(exp_q.size() == 0 && done_pend && done_at == cyc + 1));
    holdover_i = 1'b0;
    repeat (2) @(negedge clk);
    chk(host_stall_o == 1'b0, "R9 stall low after fall", int'(host_stall_o), 0);
    start_sweep(8'hFF, 2);
    wait_sweep();
    drop_hold();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule